// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block owns the stack pointer of an 8-bit processor and drives a single byte-wide synchronous memory port for every operation that touches the stack. A decoder elsewhere in the core issues one command at a time with a one-cycle `start` strobe and supplies the register values that the command needs. The block then steps through the required memory writes and reads, updates the pointer, and pulses `done` for one cycle with its results on `sp`, `pc_out`, `res` and `ccr_out`.

Supported work: byte and word pushes and pulls, an absolute and a relative subroutine call, a subroutine return, a software-interrupt entry that saves the user registers and fetches a 16-bit vector, and three pointer transfers. The pointer always addresses the next free byte: writes land at the pointer and then move it down, and reads first move it up and then fetch. The memory returns read data on the cycle after a read request.

Top module: `stk_ctrl`

## Requirements
- R1: After reset `sp` is 0x01FF, `pc_out`, `res` and `ccr_out` are zero, and `busy`, `done` and `mem_en` are low.
- R2: Command 0 (byte push) writes `op_byte` at the address in `sp`, then lowers `sp` by one.
- R3: Command 1 (byte pull) raises `sp` by one, then reads the byte at the new `sp`; `res` gets that byte with its upper eight bits zero.
- R4: Command 2 (word push) writes the low byte of `op_word` at `sp` and its high byte at `sp`-1, leaving `sp` two lower.
- R5: Command 3 (word pull) reads the high byte at `sp`+1 and the low byte at `sp`+2 into `res`, leaving `sp` two higher.
- R6: Command 4 (absolute call) pushes `pc_in` as a word, low byte first, and loads `pc_out` with `op_word`.
- R7: Command 5 (relative call) pushes `pc_in`+2 as a word, low byte first, and loads `pc_out` with `pc_in`+2 plus the sign-extended `op_byte`.
- R8: Command 6 (return) pulls a word, high byte first, into `pc_out`.
- R9: Command 7 (software interrupt) pushes nine bytes in the order `pc_in` low, `pc_in` high, `y_in` low, `y_in` high, `x_in` low, `x_in` high, `a_in`, `b_in`, `ccr_in`; sets `ccr_out` to `ccr_in` with bit 4 (the interrupt mask) forced to 1; loads `pc_out` with the byte at 0xFFF6 as its high half and the byte at 0xFFF7 as its low half; and runs whether or not bit 4 of `ccr_in` is already set.
- R10: Command 8 puts `sp`+1 on `res` without moving `sp`; command 9 loads `sp` with `op_word`-1; command 10 loads `sp` with `op_word`.
- R11: All pointer and address arithmetic wraps modulo 65536 (a push at 0x0000 leaves 0xFFFF, a pull at 0xFFFF reads address 0x0000).
- R12: `done` is high for exactly one cycle per command, at N+1 clock edges after the edge that accepts `start`, where N is one per byte written plus two per byte read (zero for commands 8 to 15); `start` is ignored while `busy` is high.
- R13: Commands 11 to 15 complete with `done` and change no output or memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the command on `cmd` when idle |
| cmd | input | 4 | Command code |
| op_word | input | 16 | Word operand: push data, call target, transfer source |
| op_byte | input | 8 | Byte operand: push data, relative displacement |
| pc_in | input | 16 | Address of the calling instruction / return point |
| x_in | input | 16 | First index register value |
| y_in | input | 16 | Second index register value |
| a_in | input | 8 | First accumulator value |
| b_in | input | 8 | Second accumulator value |
| ccr_in | input | 8 | Condition code value |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter produced by calls, return and interrupt entry |
| res | output | 16 | Pulled data or transferred pointer value |
| ccr_out | output | 8 | Condition code with the mask set by interrupt entry |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench builds the block with its defaults: 8-bit data and hence a 16-bit pointer, the vector at 0xFFF6, a reset pointer of 0x01FF and the mask at bit 4. With a 16-bit pointer a single load of 0x0000 or 0xFFFF followed by one push or pull reaches both wrap boundaries, and the vector bytes sit in the same address space that random pushes may overwrite, so the vector fetch is checked against whatever memory actually holds. Random command streams with random operands run against a bench reference model of pointer, memory and outputs, together with directed cases for negative displacements, an already-set mask and a start strobe held during a busy command.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Command codes seen on the cmd port.
    localparam logic [3:0] OP_PSH8  = 4'd0;
    localparam logic [3:0] OP_PUL8  = 4'd1;
    localparam logic [3:0] OP_PSH16 = 4'd2;
    localparam logic [3:0] OP_PUL16 = 4'd3;
    localparam logic [3:0] OP_CALL  = 4'd4;
    localparam logic [3:0] OP_RCALL = 4'd5;
    localparam logic [3:0] OP_RET   = 4'd6;
    localparam logic [3:0] OP_SWI   = 4'd7;
    localparam logic [3:0] OP_SP2IX = 4'd8;
    localparam logic [3:0] OP_IX2SP = 4'd9;
    localparam logic [3:0] OP_SPLD  = 4'd10;

    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_CAP  = 2'd3
    } stk_st_e;

    // Longest write burst (interrupt entry) and width of the step counter.
    localparam int MAX_WR = 9;
    localparam int KW     = $clog2(MAX_WR + 1);

endpackage

// File: rtl/stk_plan.sv
// Per-command access plan: how many bytes are written, how many are read,
// whether the reads come from the vector, and whether no memory is touched.
module stk_plan
    import stk_pkg::*;
(
    input  logic [3:0]    cmd,
    output logic [KW-1:0] n_wr,
    output logic [KW-1:0] n_rd,
    output logic          vec,
    output logic          quick
);
    always_comb begin
        n_wr  = '0;
        n_rd  = '0;
        vec   = 1'b0;
        quick = 1'b0;
        case (cmd)
            OP_PSH8:  n_wr = KW'(1);
            OP_PUL8:  n_rd = KW'(1);
            OP_PSH16: n_wr = KW'(2);
            OP_PUL16: n_rd = KW'(2);
            OP_CALL:  n_wr = KW'(2);
            OP_RCALL: n_wr = KW'(2);
            OP_RET:   n_rd = KW'(2);
            OP_SWI: begin
                n_wr = KW'(MAX_WR);
                n_rd = KW'(2);
                vec  = 1'b1;
            end
            default:  quick = 1'b1;
        endcase
    end
endmodule

// File: rtl/stk_wsel.sv
// Picks the byte for write step idx of the current command.
module stk_wsel
    import stk_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [3:0]    cmd,
    input  logic [KW-1:0] idx,
    input  logic [AW-1:0] opw,
    input  logic [DW-1:0] opb,
    input  logic [AW-1:0] ret,
    input  logic [AW-1:0] xs,
    input  logic [AW-1:0] ys,
    input  logic [DW-1:0] a_s,
    input  logic [DW-1:0] b_s,
    input  logic [DW-1:0] c_s,
    output logic [DW-1:0] wbyte
);
    // Low half on even steps, high half on odd steps.
    function automatic logic [DW-1:0] half(input logic [AW-1:0] w, input logic hi);
        return hi ? w[AW-1:DW] : w[DW-1:0];
    endfunction

    always_comb begin
        wbyte = '0;
        case (cmd)
            OP_PSH8:            wbyte = opb;
            OP_PSH16:           wbyte = half(opw, idx[0]);
            OP_CALL, OP_RCALL:  wbyte = half(ret, idx[0]);
            OP_SWI: begin
                case (idx)
                    KW'(0), KW'(1): wbyte = half(ret, idx[0]);
                    KW'(2), KW'(3): wbyte = half(ys, idx[0]);
                    KW'(4), KW'(5): wbyte = half(xs, idx[0]);
                    KW'(6):         wbyte = a_s;
                    KW'(7):         wbyte = b_s;
                    default:        wbyte = c_s;
                endcase
            end
            default:            wbyte = '0;
        endcase
    end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] VEC_BASE = 16'hFFF6,
    parameter logic [2*DW-1:0] SP_RESET = 16'h01FF,
    parameter int IMASK_BIT = 4,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    cmd,
    input  logic [AW-1:0] op_word,
    input  logic [DW-1:0] op_byte,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] y_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] ccr_in,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] res,
    output logic [DW-1:0] ccr_out,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    localparam logic [AW-1:0] ONE_W = AW'(1);
    localparam logic [AW-1:0] TWO_W = AW'(2);
    localparam logic [DW-1:0] MASK  = DW'(1) << IMASK_BIT;

    typedef struct packed {
        stk_st_e       st;
        logic [AW-1:0] sp;
        logic [AW-1:0] pc;
        logic [AW-1:0] res;
        logic [DW-1:0] ccr;
        logic [AW-1:0] acc;
        logic [KW-1:0] k;
        logic          done;
        logic [3:0]    cmd;
        logic [AW-1:0] opw;
        logic [AW-1:0] pcs;
        logic [AW-1:0] xs;
        logic [AW-1:0] ys;
        logic [DW-1:0] opb;
        logic [DW-1:0] a_s;
        logic [DW-1:0] b_s;
        logic [DW-1:0] c_s;
    } regs_t;

    regs_t q, n;

    // Plan is decoded from the port while idle, from the held command after.
    logic [3:0]    plan_cmd;
    logic [KW-1:0] n_wr, n_rd;
    logic          plan_vec, plan_quick;
    logic          rd_vec;
    logic [AW-1:0] ret_w;
    logic [DW-1:0] wbyte;

    assign plan_cmd = (q.st == ST_IDLE) ? cmd : q.cmd;

    stk_plan u_plan (
        .cmd   (plan_cmd),
        .n_wr  (n_wr),
        .n_rd  (n_rd),
        .vec   (plan_vec),
        .quick (plan_quick)
    );

    // Return address: relative call skips its own two bytes.
    assign ret_w = (q.cmd == OP_RCALL) ? (q.pcs + TWO_W) : q.pcs;

    stk_wsel #(.DW(DW)) u_wsel (
        .cmd   (q.cmd),
        .idx   (q.k),
        .opw   (q.opw),
        .opb   (q.opb),
        .ret   (ret_w),
        .xs    (q.xs),
        .ys    (q.ys),
        .a_s   (q.a_s),
        .b_s   (q.b_s),
        .c_s   (q.c_s),
        .wbyte (wbyte)
    );

    assign rd_vec = plan_vec && (q.st == ST_RD);

    logic          fin;
    logic [AW-1:0] addr_c;
    logic          en_c, we_c;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        fin    = 1'b0;
        en_c   = 1'b0;
        we_c   = 1'b0;
        addr_c = q.sp;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.cmd = cmd;
                    n.opw = op_word;
                    n.opb = op_byte;
                    n.pcs = pc_in;
                    n.xs  = x_in;
                    n.ys  = y_in;
                    n.a_s = a_in;
                    n.b_s = b_in;
                    n.c_s = ccr_in;
                    n.k   = '0;
                    n.acc = '0;
                    if (plan_quick) begin
                        n.done = 1'b1;
                        case (cmd)
                            OP_SP2IX: n.res = q.sp + ONE_W;
                            OP_IX2SP: n.sp  = op_word - ONE_W;
                            OP_SPLD:  n.sp  = op_word;
                            default:  n.sp  = q.sp;
                        endcase
                    end else if (n_wr != '0) begin
                        n.st = ST_WR;
                    end else begin
                        n.st = ST_RD;
                    end
                end
            end

            ST_WR: begin
                en_c   = 1'b1;
                we_c   = 1'b1;
                addr_c = q.sp;
                n.sp   = q.sp - ONE_W;
                n.k    = q.k + KW'(1);
                if (q.k == n_wr - KW'(1)) begin
                    n.k = '0;
                    if (n_rd != '0) n.st = ST_RD;
                    else            fin  = 1'b1;
                end
            end

            ST_RD: begin
                en_c = 1'b1;
                if (plan_vec) begin
                    addr_c = VEC_BASE + AW'(q.k);
                end else begin
                    addr_c = q.sp + ONE_W;
                    n.sp   = q.sp + ONE_W;
                end
                n.st = ST_CAP;
            end

            ST_CAP: begin
                n.acc = {q.acc[DW-1:0], mem_rdata};
                n.k   = q.k + KW'(1);
                if (q.k == n_rd - KW'(1)) fin  = 1'b1;
                else                      n.st = ST_RD;
            end

            default: n.st = ST_IDLE;
        endcase

        if (fin) begin
            n.st   = ST_IDLE;
            n.done = 1'b1;
            n.k    = '0;
            case (q.cmd)
                OP_PUL8, OP_PUL16: n.res = n.acc;
                OP_CALL:           n.pc  = q.opw;
                OP_RCALL:          n.pc  = ret_w + {{DW{q.opb[DW-1]}}, q.opb};
                OP_RET:            n.pc  = n.acc;
                OP_SWI: begin
                    n.pc  = n.acc;
                    n.ccr = q.c_s | MASK;
                end
                default:           n.pc  = q.pc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.sp <= SP_RESET;
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign sp        = q.sp;
    assign pc_out    = q.pc;
    assign res       = q.res;
    assign ccr_out   = q.ccr;
    assign mem_en    = en_c;
    assign mem_we    = we_c;
    assign mem_addr  = addr_c;
    assign mem_wdata = wbyte;

endmodule

// File: rtl/stk_ctrl_chk.sv
module stk_ctrl_chk #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] VEC_BASE = 16'hFFF6,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] sp,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          rd_vec
);
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    a_r12_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

    a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr == sp));

    a_r2_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (sp == $past(sp) - AW'(1)));

    a_r3_read_preinc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && !rd_vec) |-> (mem_addr == sp + AW'(1)));

    a_r3_read_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && !rd_vec) |=> (sp == $past(mem_addr)));

    a_r9_vector_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && rd_vec) |-> (mem_addr == VEC_BASE || mem_addr == VEC_BASE + AW'(1)));

    a_r9_vector_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && rd_vec) |=> $stable(sp));

endmodule

bind stk_ctrl stk_ctrl_chk #(.DW(DW), .VEC_BASE(VEC_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sp       (sp),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rd_vec   (rd_vec)
);

// File: tb/tb_stk_ctrl.sv
module tb_stk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic [15:0] op_word = '0, pc_in = '0, x_in = '0, y_in = '0;
    logic [7:0]  op_byte = '0, a_in = '0, b_in = '0, ccr_in = '0;
    logic [7:0]  mem_rdata;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] sp, pc_out, res, mem_addr;
    logic [7:0]  ccr_out, mem_wdata;

    stk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .op_word(op_word), .op_byte(op_byte), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp(sp),
        .pc_out(pc_out), .res(res), .ccr_out(ccr_out), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #4 clk = ~clk;

    // Memory attached to the design, and the reference copy.
    logic [7:0] dmem [int];
    logic [7:0] mmem [int];
    int         touched [$];

    initial mem_rdata = 8'h00;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 8'h00;
        end
    end

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] msp = 16'h01FF, mpc = '0, mres = '0;
    logic [7:0]  mccr = '0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic string rq_of(input logic [3:0] c);
        case (c)
            4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R5";  4'd4: return "R6";  4'd5: return "R7";
            4'd6: return "R8";  4'd7: return "R9";
            4'd8, 4'd9, 4'd10: return "R10";
            default: return "R13";
        endcase
    endfunction

    function automatic int lat_of(input logic [3:0] c);
        case (c)
            4'd0: return 1; 4'd1: return 2; 4'd2: return 2; 4'd3: return 4;
            4'd4: return 2; 4'd5: return 2; 4'd6: return 4; 4'd7: return 13;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] mrd(input logic [15:0] a);
        return mmem.exists(int'(a)) ? mmem[int'(a)] : 8'h00;
    endfunction

    function automatic void mpush(input logic [7:0] b);
        mmem[int'(msp)] = b;
        touched.push_back(int'(msp));
        msp = msp - 16'd1;
    endfunction

    function automatic logic [7:0] mpull();
        msp = msp + 16'd1;
        return mrd(msp);
    endfunction

    function automatic void mpushw(input logic [15:0] w);
        mpush(w[7:0]);
        mpush(w[15:8]);
    endfunction

    function automatic logic [15:0] mpullw();
        logic [7:0] h;
        h = mpull();
        return {h, mpull()};
    endfunction

    function automatic void model(input logic [3:0] c, input logic [15:0] w, input logic [7:0] b,
                                  input logic [15:0] pc, input logic [15:0] x, input logic [15:0] y,
                                  input logic [7:0] a, input logic [7:0] bb, input logic [7:0] cc);
        logic [15:0] r;
        case (c)
            4'd0: mpush(b);
            4'd1: mres = {8'h00, mpull()};
            4'd2: mpushw(w);
            4'd3: mres = mpullw();
            4'd4: begin mpushw(pc); mpc = w; end
            4'd5: begin r = pc + 16'd2; mpushw(r); mpc = r + {{8{b[7]}}, b}; end
            4'd6: mpc = mpullw();
            4'd7: begin
                mpushw(pc); mpushw(y); mpushw(x); mpush(a); mpush(bb); mpush(cc);
                mccr = cc | 8'h10;
                mpc  = {mrd(16'hFFF6), mrd(16'hFFF7)};
            end
            4'd8:  mres = msp + 16'd1;
            4'd9:  msp  = w - 16'd1;
            4'd10: msp  = w;
            default: ;
        endcase
    endfunction

    task automatic run(input logic [3:0] c, input logic [15:0] w, input logic [7:0] b,
                       input logic [15:0] pc, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] a, input logic [7:0] bb, input logic [7:0] cc,
                       input bit glitch);
        int n;
        string rq;
        rq = rq_of(c);
        touched.delete();
        @(negedge clk);
        cmd = c; op_word = w; op_byte = b; pc_in = pc; x_in = x; y_in = y;
        a_in = a; b_in = bb; ccr_in = cc; start = 1'b1;
        @(posedge clk); #2;
        // R12: a held start during a busy command must be ignored
        start = glitch;
        if (glitch) begin cmd = 4'd10; op_word = 16'h1234; end
        n = 1;
        while (!done && n < 100) begin
            @(posedge clk); #2;
            n++;
            if (n >= 3) start = 1'b0;
        end
        start = 1'b0;
        model(c, w, b, pc, x, y, a, bb, cc);
        chk("R12 latency", n, lat_of(c) + 1);
        chk({rq, " sp"}, sp, msp);
        chk({rq, " pc"}, pc_out, mpc);
        chk({rq, " res"}, res, mres);
        chk({rq, " ccr"}, ccr_out, mccr);
        foreach (touched[i]) begin
            chk({rq, " mem"}, dmem.exists(touched[i]) ? dmem[touched[i]] : 8'hxx, mmem[touched[i]]);
        end
        @(posedge clk); #2;
        chk("R12 done width", done, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Vector bytes, identical in both memories.
        dmem[32'hFFF6] = 8'hC1; mmem[32'hFFF6] = 8'hC1;
        dmem[32'hFFF7] = 8'h23; mmem[32'hFFF7] = 8'h23;

        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 sp", sp, 16'h01FF);
        chk("R1 pc", pc_out, 16'h0);
        chk("R1 res", res, 16'h0);
        chk("R1 ccr", ccr_out, 8'h0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 mem_en", mem_en, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // Directed cases
        run(4'd0, 16'h0, 8'hA5, 0, 0, 0, 0, 0, 0, 0);           // R2
        run(4'd1, 16'h0, 8'h00, 0, 0, 0, 0, 0, 0, 0);           // R3
        run(4'd2, 16'hBEEF, 8'h0, 0, 0, 0, 0, 0, 0, 0);         // R4
        run(4'd3, 16'h0, 8'h0, 0, 0, 0, 0, 0, 0, 0);            // R5
        run(4'd4, 16'h4000, 8'h0, 16'h1234, 0, 0, 0, 0, 0, 0);  // R6
        run(4'd6, 16'h0, 8'h0, 0, 0, 0, 0, 0, 0, 0);            // R8
        run(4'd5, 16'h0, 8'h80, 16'h2000, 0, 0, 0, 0, 0, 0);    // R7 negative displacement
        run(4'd5, 16'h0, 8'h1E, 16'h2000, 0, 0, 0, 0, 0, 0);    // R7 positive displacement
        run(4'd7, 16'h0, 8'h0, 16'h3456, 16'h1122, 16'h3344, 8'h55, 8'h66, 8'h10, 1); // R9 mask set, R12 glitch
        run(4'd7, 16'h0, 8'h0, 16'h789A, 16'hABCD, 16'hEF01, 8'h77, 8'h88, 8'hC5, 0); // R9
        run(4'd8, 16'h0, 8'h0, 0, 0, 0, 0, 0, 0, 0);            // R10 pointer to index
        run(4'd9, 16'h0000, 8'h0, 0, 0, 0, 0, 0, 0, 0);         // R10, R11 index to pointer wraps
        run(4'd10, 16'h0000, 8'h0, 0, 0, 0, 0, 0, 0, 0);        // R10 load
        run(4'd0, 16'h0, 8'h3C, 0, 0, 0, 0, 0, 0, 0);           // R11 push at 0x0000
        run(4'd1, 16'h0, 8'h0, 0, 0, 0, 0, 0, 0, 0);            // R11 pull from 0xFFFF
        run(4'd12, 16'hFFFF, 8'hFF, 16'hFFFF, 0, 0, 8'hFF, 8'hFF, 8'hFF, 0); // R13
        run(4'd10, 16'h0300, 8'h0, 0, 0, 0, 0, 0, 0, 0);

        // Random streams
        for (int i = 0; i < 400; i++) begin
            logic [3:0] c;
            c = 4'($urandom_range(0, 13));
            if (c == 4'd9 || c == 4'd10) begin
                run(c, 16'($urandom), 8'($urandom), 0, 0, 0, 0, 0, 0, 0);
            end else begin
                run(c, 16'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                    8'($urandom), 8'($urandom), 8'($urandom), (i % 17) == 0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        bad++;
        total++;
        $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule